// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the request and priority core of one eight-line interrupt controller. Each input line is captured into a pending-request register. A per-line trigger-mode register chooses whether the line is captured on its rising edge or tracked as a level. A mask register removes lines from arbitration. An in-service register records the lines that are currently being serviced. A rotating offset sets which line holds the top priority.

Every cycle, a combinational resolver finds the best-ranked unmasked pending line and compares it with the best-ranked in-service line. It reports a winner only when the pending line strictly outranks everything in service. A registered interrupt output follows the winner flag. A primary instance can leave its cascade line out of the in-service comparison. This lets a secondary controller's higher-priority requests get through while the cascade line is still in service.

Configuration (trigger modes, mask, in-service contents, offset, nesting mode) comes from a separate register decoder. Request clearing on acknowledge also comes from outside, as a per-line clear vector. Acknowledge sequencing and bus decoding are not part of this block.

Top module: `irq_prio_core`

## Requirements
- R1: A line in level mode (trigger bit 1) has its request bit equal to the input value sampled at the previous clock edge; the request clear vector has no effect on it.
- R2: A line in edge mode (trigger bit 0) has its request bit set by a rising input, detected against a stored previous input level. A falling input leaves the request bit unchanged. Bit i of `req_clr` clears an edge-mode request, but a rising edge in the same cycle takes precedence and sets the bit.
- R3: A trigger-mode write stores the data ANDed with a fixed writable mask. The mask is 0xF8 on the primary instance and 0xDE on the secondary. Bits outside the mask always read back as 0 (edge mode).
- R4: Priority rank k belongs to line (k + offset) mod 8. Among the candidate lines, the smallest rank wins.
- R5: The candidates are the request bits that are not masked (mask bit 1 = masked). `win_valid` is 1 only when the best candidate rank is strictly smaller than the best in-service rank. A line that is itself in service can therefore never win.
- R6: On the primary instance with `nest_en` = 1, in-service bit 2 is ignored when the in-service rank is computed. On a secondary instance `nest_en` has no effect.
- R7: `win_line` equals (winning rank + offset) mod 8 when `win_valid` is 1, and 0 otherwise.
- R8: `irq_out` is a register that equals the previous cycle's `win_valid`.
- R9: A synchronous active-low reset clears the request, previous-level, trigger, mask, in-service and offset registers and `irq_out`.
- R10: Mask, in-service and offset writes take effect at the next clock edge, and the resolver outputs reflect them in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 8 | Interrupt input lines |
| req_clr | input | 8 | Per-line clear of edge-mode requests |
| trig_wr_en | input | 1 | Trigger-mode register write strobe |
| trig_wr_data | input | 8 | Trigger-mode write data (1 = level) |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 8 | Mask write data (1 = masked) |
| isr_wr_en | input | 1 | In-service register write strobe |
| isr_wr_data | input | 8 | In-service write data |
| off_wr_en | input | 1 | Priority offset write strobe |
| off_wr_data | input | 3 | Line that takes rank 0 |
| nest_en | input | 1 | Exclude cascade line from in-service rank (primary only) |
| req_q | output | 8 | Current request register |
| trig_q | output | 8 | Current trigger-mode register |
| win_valid | output | 1 | A request outranks all in-service lines |
| win_line | output | 3 | Index of the winning line |
| irq_out | output | 1 | Registered interrupt request |

## Verification
The bench targets the strict comparison. A pending line with the same rank as an in-service line must not win; a design using "less or equal" would raise an interrupt for a line that is already being serviced. Rotation is exercised at several offsets, including wraparound, where a design that did not take the offset modulo 8 would report the wrong line or no line at all. The bench also checks that a falling edge-mode input keeps its request, that level lines follow the input and ignore the clear vector, that unwritable trigger bits read back as edge, and that cascade-line exclusion applies only when nesting is enabled. Any mistake there shows up as a lost interrupt, a sticky interrupt, or a request blocked by its own cascade.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
    parameter int LINES = 8;
    localparam int IDX_W = $clog2(LINES);
    localparam int RANK_W = IDX_W + 1;

    typedef logic [LINES-1:0]  line_vec_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [RANK_W-1:0] rank_t;

    localparam line_vec_t PRI_TRIG_WMASK = line_vec_t'(8'hF8);
    localparam line_vec_t SEC_TRIG_WMASK = line_vec_t'(8'hDE);
endpackage

// File: rtl/irq_capture.sv
module irq_capture
    import irq_prio_pkg::*;
#(
    parameter line_vec_t WMASK = PRI_TRIG_WMASK
) (
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t irq_in,
    input  line_vec_t req_clr,
    input  logic      trig_wr_en,
    input  line_vec_t trig_wr_data,
    output line_vec_t req_q,
    output line_vec_t trig_q
);
    typedef struct packed {
        line_vec_t req;
        line_vec_t prev;
        line_vec_t trig;
    } cap_t;

    cap_t cap_d, cap_q;
    line_vec_t edge_req;

    always_comb begin
        cap_d    = cap_q;
        edge_req = (cap_q.req & ~req_clr) | (irq_in & ~cap_q.prev);
        cap_d.req  = (cap_q.trig & irq_in) | (~cap_q.trig & edge_req);
        cap_d.prev = irq_in;
        if (trig_wr_en) begin
            cap_d.trig = trig_wr_data & WMASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign req_q  = cap_q.req;
    assign trig_q = cap_q.trig;

    // R1: level lines track the input of the previous cycle
    a_r1_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & $past(trig_q)) == ($past(irq_in) & $past(trig_q))));

    // R2: an edge-mode request survives unless explicitly cleared
    a_r2_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req_q) & ~$past(trig_q) & ~$past(req_clr) & ~req_q) == '0));

    // R3: trigger writes are filtered through the writable mask
    a_r3_trig_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        trig_wr_en |=> (trig_q == ($past(trig_wr_data) & WMASK)));
endmodule

// File: rtl/irq_rank.sv
module irq_rank
    import irq_prio_pkg::*;
(
    input  line_vec_t vec,
    input  idx_t      off,
    output rank_t     rank
);
    line_vec_t rot;

    always_comb begin
        for (int k = 0; k < LINES; k++) begin
            idx_t sel;
            sel    = idx_t'(k) + off;
            rot[k] = vec[sel];
        end
    end

    always_comb begin
        rank = rank_t'(LINES);
        for (int k = LINES - 1; k >= 0; k--) begin
            if (rot[k]) begin
                rank = rank_t'(k);
            end
        end
    end
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
    import irq_prio_pkg::*;
#(
    parameter bit IS_PRIMARY   = 1'b1,
    parameter int CASCADE_LINE = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] irq_in,
    input  logic [7:0] req_clr,
    input  logic       trig_wr_en,
    input  logic [7:0] trig_wr_data,
    input  logic       mask_wr_en,
    input  logic [7:0] mask_wr_data,
    input  logic       isr_wr_en,
    input  logic [7:0] isr_wr_data,
    input  logic       off_wr_en,
    input  logic [2:0] off_wr_data,
    input  logic       nest_en,
    output logic [7:0] req_q,
    output logic [7:0] trig_q,
    output logic       win_valid,
    output logic [2:0] win_line,
    output logic       irq_out
);
    localparam line_vec_t TRIG_WMASK = IS_PRIMARY ? PRI_TRIG_WMASK : SEC_TRIG_WMASK;
    localparam line_vec_t CASC_BIT   = line_vec_t'(1) << CASCADE_LINE;

    typedef struct packed {
        line_vec_t mask;
        line_vec_t isr;
        idx_t      off;
        logic      irq;
    } core_t;

    core_t     st_d, st_q;
    line_vec_t cand_vec, isr_eff;
    rank_t     cand_rank, isr_rank;

    irq_capture #(.WMASK(TRIG_WMASK)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_in       (irq_in),
        .req_clr      (req_clr),
        .trig_wr_en   (trig_wr_en),
        .trig_wr_data (trig_wr_data),
        .req_q        (req_q),
        .trig_q       (trig_q)
    );

    assign cand_vec = req_q & ~st_q.mask;

    generate
        if (IS_PRIMARY) begin : g_nest
            assign isr_eff = nest_en ? (st_q.isr & ~CASC_BIT) : st_q.isr;
        end else begin : g_plain
            assign isr_eff = st_q.isr;
        end
    endgenerate

    irq_rank u_cand_rank (.vec(cand_vec), .off(st_q.off), .rank(cand_rank));
    irq_rank u_isr_rank  (.vec(isr_eff),  .off(st_q.off), .rank(isr_rank));

    assign win_valid = (cand_rank < isr_rank);
    assign win_line  = win_valid ? idx_t'(cand_rank[IDX_W-1:0] + st_q.off) : '0;

    always_comb begin
        st_d     = st_q;
        st_d.irq = win_valid;
        if (mask_wr_en) st_d.mask = mask_wr_data;
        if (isr_wr_en)  st_d.isr  = isr_wr_data;
        if (off_wr_en)  st_d.off  = off_wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_out = st_q.irq;

    // R5: a reported winner is an unmasked pending line
    a_r5_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (req_q[win_line] && !st_q.mask[win_line]));

    // R5 / R6: a winner is never already in service, unless it is the excluded cascade line
    a_r5_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid && !(IS_PRIMARY && nest_en && win_line == idx_t'(CASCADE_LINE)))
            |-> !st_q.isr[win_line]);

    // R7: no winner reports line zero
    a_r7_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid |-> (win_line == '0));

    // R8: the interrupt output lags the winner flag by one cycle
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_out == $past(win_valid)));

    // R10: a mask write lands at the next edge
    a_r10_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> (st_q.mask == $past(mask_wr_data)));
endmodule

// File: tb/irq_prio_core_test.sv
module irq_prio_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0, req_clr = '0;
    logic       trig_wr_en = 1'b0, mask_wr_en = 1'b0, isr_wr_en = 1'b0, off_wr_en = 1'b0;
    logic [7:0] trig_wr_data = '0, mask_wr_data = '0, isr_wr_data = '0;
    logic [2:0] off_wr_data = '0;
    logic       nest_en = 1'b0;
    logic [7:0] req_q, trig_q;
    logic       win_valid, irq_out;
    logic [2:0] win_line;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    int m_req = 0, m_prev = 0, m_trig = 0, m_mask = 0, m_isr = 0, m_off = 0, m_irq = 0;

    always #10 clk = ~clk;

    irq_prio_core uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_clr(req_clr),
        .trig_wr_en(trig_wr_en), .trig_wr_data(trig_wr_data),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .isr_wr_en(isr_wr_en), .isr_wr_data(isr_wr_data),
        .off_wr_en(off_wr_en), .off_wr_data(off_wr_data),
        .nest_en(nest_en), .req_q(req_q), .trig_q(trig_q),
        .win_valid(win_valid), .win_line(win_line), .irq_out(irq_out)
    );

    function automatic int rank_of(int v, int off);
        for (int k = 0; k < 8; k++)
            if (((v >> ((k + off) % 8)) & 1) != 0) return k;
        return 8;
    endfunction

    function automatic int exp_valid();
        int iv;
        iv = m_isr;
        if (nest_en) iv = iv & ~32'h4;
        return (rank_of(m_req & ~m_mask & 8'hFF, m_off) < rank_of(iv, m_off)) ? 1 : 0;
    endfunction

    function automatic int exp_line();
        if (exp_valid() == 0) return 0;
        return (rank_of(m_req & ~m_mask & 8'hFF, m_off) + m_off) % 8;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference update at each edge
    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            m_req = 0; m_prev = 0; m_trig = 0; m_mask = 0; m_isr = 0; m_off = 0; m_irq = 0;
        end else begin
            int lvl, edg;
            m_irq = exp_valid();
            lvl = m_trig & irq_in;
            edg = ~m_trig & ((m_req & ~req_clr) | (irq_in & ~m_prev));
            m_req = (lvl | edg) & 8'hFF;
            m_prev = irq_in;
            if (trig_wr_en) m_trig = trig_wr_data & 8'hF8;
            if (mask_wr_en) m_mask = mask_wr_data;
            if (isr_wr_en)  m_isr = isr_wr_data;
            if (off_wr_en)  m_off = off_wr_data;
        end
    end

    // per-cycle comparison, mid-cycle
    always @(negedge clk) begin
        if (started && !done) begin
            chk(req_q == m_req[7:0], "R1/R2 req", req_q, m_req);
            chk(trig_q == m_trig[7:0], "R3 trig", trig_q, m_trig);
            chk(win_valid == exp_valid(), "R5 valid", win_valid, exp_valid());
            chk(win_line == exp_line(), "R4/R7 line", win_line, exp_line());
            chk(irq_out == m_irq, "R8 irq", irq_out, m_irq);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic clear_strobes();
        trig_wr_en = 0; mask_wr_en = 0; isr_wr_en = 0; off_wr_en = 0; req_clr = '0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        step(3);
        // R9: reset state
        chk(req_q == 0 && trig_q == 0 && irq_out == 0 && win_valid == 0, "R9 reset", {req_q, trig_q}, 0);
        rst_n = 1;
        step(1);

        // R3: unwritable trigger bits stay edge
        trig_wr_data = 8'hFF; trig_wr_en = 1; step(1); clear_strobes(); #1;
        chk(trig_q == 8'hF8, "R3 trig mask", trig_q, 8'hF8);

        // R1: level line 5 follows the input, ignores clear
        irq_in[5] = 1; step(1); #1;
        chk(req_q[5] == 1, "R1 level high", req_q[5], 1);
        req_clr[5] = 1; step(1); req_clr = '0; #1;
        chk(req_q[5] == 1, "R1 clear ignored", req_q[5], 1);
        irq_in[5] = 0; step(1); #1;
        chk(req_q[5] == 0, "R1 level low", req_q[5], 0);

        // R2: edge line 0 holds after falling, clear drops it
        irq_in[0] = 1; step(1); irq_in[0] = 0; step(1); #1;
        chk(req_q[0] == 1, "R2 edge held", req_q[0], 1);
        req_clr[0] = 1; step(1); req_clr = '0; #1;
        chk(req_q[0] == 0, "R2 edge cleared", req_q[0], 0);

        // R4: rotation picks different winners
        irq_in[0] = 1; irq_in[1] = 1; step(1); #1;
        chk(win_valid && win_line == 0, "R4 offset0", win_line, 0);
        off_wr_data = 3'd1; off_wr_en = 1; step(1); clear_strobes(); #1;
        chk(win_valid && win_line == 1, "R4 R10 offset1", win_line, 1);
        off_wr_data = 3'd7; off_wr_en = 1; step(1); clear_strobes(); #1;
        chk(win_valid && win_line == 0, "R4 wrap offset7", win_line, 0);
        step(1); #1;
        chk(irq_out == 1, "R8 irq raised", irq_out, 1);

        // R5 / R10: masking and strict in-service comparison
        off_wr_data = 3'd0; off_wr_en = 1; mask_wr_data = 8'h01; mask_wr_en = 1;
        step(1); clear_strobes(); #1;
        chk(win_valid && win_line == 1, "R5 R10 mask", win_line, 1);
        mask_wr_data = 8'h00; mask_wr_en = 1; isr_wr_data = 8'h01; isr_wr_en = 1;
        step(1); clear_strobes(); #1;
        chk(win_valid == 0, "R5 equal rank blocked", win_valid, 0);

        // R6: cascade line exclusion
        irq_in[1:0] = 2'b00; req_clr = 8'h03; isr_wr_data = 8'h04; isr_wr_en = 1;
        step(1); clear_strobes();
        irq_in[2] = 1; step(1); #1;
        chk(win_valid == 0, "R6 cascade in service", win_valid, 0);
        nest_en = 1; #1;
        chk(win_valid && win_line == 2, "R6 nested exclusion", win_line, 2);
        nest_en = 0; irq_in = '0;

        // mixed stimulus against the reference model
        for (int i = 0; i < 4000; i++) begin
            irq_in = 8'($urandom);
            req_clr = 8'($urandom) & 8'($urandom);
            trig_wr_en = ($urandom % 16) == 0; trig_wr_data = 8'($urandom);
            mask_wr_en = ($urandom % 8) == 0;  mask_wr_data = 8'($urandom) & 8'($urandom);
            isr_wr_en = ($urandom % 8) == 0;   isr_wr_data = 8'($urandom) & 8'($urandom);
            off_wr_en = ($urandom % 8) == 0;   off_wr_data = 3'($urandom);
            nest_en = 1'($urandom);
            rst_n = ($urandom % 500) != 0;
            step(1);
        end
        clear_strobes(); rst_n = 1;
        step(2);
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
        end
    end
endmodule